// File: doc/BRIEF.md
# Multi-Channel Clock-Lock Reset Supervisor

This block drives the reset lines of a group of phase-shifting clock managers. Each manager recovers a source-synchronous data clock that an external converter sends back. The converter's own input clock comes from a master PLL. Until that PLL reports lock, every manager is held in reset. Once the PLL locks, all managers stay in reset for a further settling interval, so that the returned clocks have time to start.

After release, each channel checks and recovers on its own. A channel is declared good only when its lock input is high at the end of a fixed check window. If lock is missing at that moment, or if lock drops while the channel is running, that channel alone gets a short reset pulse. The pulse is followed by a wait that is longer than the worst-case lock time, and then lock is sampled again. This repeats for as long as needed. Each channel reports whether it is ready, how many reset pulses it has been given, and a sticky error once too many checks in a row have failed. Downstream capture logic gates its use of a channel's clock with that channel's ready output.

Top module: `clk_lock_supervisor`

## Requirements
- R1: While the master lock input is low, or during synchronous reset, every `chan_rst` bit is 1 and every `chan_ready` bit is 0, whatever the channel lock inputs do.
- R2: The first rising clock edge at which `chan_rst` is 0 is the SETTLE_CYC+3rd edge after `pll_locked` rises. This is 2 edges of synchronizer, SETTLE_CYC edges of settling count and 1 edge of state register.
- R3: After release, a channel whose lock stays high raises `chan_ready` exactly WAIT_CYC clock edges after its reset falls.
- R4: When a running channel's lock input falls, its `chan_rst` rises 3 edges later and stays high for exactly PULSE_CYC cycles.
- R5: A loss of lock or a recovery on one channel leaves the `chan_ready` and `chan_rst` of every other channel unchanged.
- R6: After a reset pulse the channel waits exactly WAIT_CYC cycles before it samples lock. Lock toggling inside the wait neither shortens nor ends the wait.
- R7: If lock is absent at the end of the wait, a new reset pulse starts on the next edge, so pulses repeat with a period of PULSE_CYC+WAIT_CYC cycles until lock is seen.
- R8: `retry_cnt` (8 bits per channel, channel c at bits [8c+7:8c]) counts reset pulses issued after release. It saturates at 255 and clears to 0 while the master lock is absent.
- R9: `chan_err` of a channel becomes 1 at the edge that starts the pulse after its ERR_LIMIT-th consecutive failed check. It stays 1 through recovery and master lock loss, and only synchronous reset clears it.
- R10: When the master lock falls, every channel shows reset high and ready low within 4 edges, and the full settling interval is counted again before the next release.
- R11: `chan_ready` is 1 only while a channel is running. It is never 1 together with `chan_rst`, and it is 0 throughout the pulse and the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_locked | input | 1 | Master PLL lock, asynchronous |
| chan_locked | input | NUM_CH | Lock flag of each clock manager, asynchronous |
| chan_rst | output | NUM_CH | Reset to each clock manager, active high |
| chan_ready | output | NUM_CH | Channel clock usable |
| retry_cnt | output | 8*NUM_CH | Saturating reset-pulse count per channel |
| chan_err | output | NUM_CH | Sticky excessive-retry flag per channel |

## Verification
The assertions assume that every lock input has already passed through the two-flop synchronizer. They also assume that the settling-release signal moves only with the master lock, so a channel never sees release while the PLL is down. The stimulus changes lock inputs only on falling clock edges. It holds each level for at least three cycles around every window boundary, so the synchronizer latency never moves a sample point, and lock glitches used to test the wait fall well inside the window.

// File: rtl/clksup_pkg.sv
package clksup_pkg;
  typedef enum logic [1:0] {
    CS_HOLD  = 2'd0,
    CS_RUN   = 2'd1,
    CS_PULSE = 2'd2,
    CS_WAIT  = 2'd3
  } chan_state_t;
endpackage

// File: rtl/clksup_sync.sv
// Multi-bit two-stage (or deeper) synchronizer; bits are independent.
module clksup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clksup_settle.sv
// Global power-up hold: release only after the master lock has been
// continuously present for SETTLE_CYC cycles.
module clksup_settle #(
  parameter int SETTLE_CYC = 50_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_s,
  output logic released
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pll_s) begin
      cnt      <= '0;
      released <= 1'b0;
    end else if (!released) begin
      if (cnt == CW'(SETTLE_CYC - 1)) released <= 1'b1;
      else                            cnt      <= cnt + 1'b1;
    end
  end

  // R2 / R10: no release is ever granted while the master lock is absent
  a_r2_no_release_unlocked: assert property (@(posedge clk) disable iff (rst)
    !pll_s |=> !released);

  // R2: release only after the count saw the full interval
  a_r2_count_before_release: assert property (@(posedge clk) disable iff (rst)
    $rose(released) |-> $past(cnt) == CW'(SETTLE_CYC - 1));
endmodule

// File: rtl/clksup_chan.sv
// Per-channel recovery loop: HOLD -> WAIT -> (RUN | PULSE -> WAIT ...)
module clksup_chan
  import clksup_pkg::*;
#(
  parameter int PULSE_CYC = 8,
  parameter int WAIT_CYC  = 32_500,
  parameter int ERR_LIMIT = 4,
  parameter int RETRY_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               released,
  input  logic               lock_s,
  output logic               chan_rst,
  output logic               chan_ready,
  output logic [RETRY_W-1:0] retry_cnt,
  output logic               chan_err
);
  localparam int TMAX = (PULSE_CYC > WAIT_CYC) ? PULSE_CYC : WAIT_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int FW   = $clog2(ERR_LIMIT + 1);
  localparam logic [RETRY_W-1:0] RMAX = {RETRY_W{1'b1}};

  chan_state_t st, nxt;
  logic [TW-1:0] tmr;
  logic [FW-1:0] fails;
  logic retry_inc, fail_inc, fail_clr;
  logic pulse_end, wait_end;

  assign pulse_end = (tmr == TW'(PULSE_CYC - 1));
  assign wait_end  = (tmr == TW'(WAIT_CYC - 1));

  always_comb begin
    nxt       = st;
    retry_inc = 1'b0;
    fail_inc  = 1'b0;
    fail_clr  = 1'b0;
    case (st)
      CS_HOLD:  nxt = CS_WAIT;
      CS_RUN: begin
        if (!lock_s) begin
          nxt       = CS_PULSE;
          retry_inc = 1'b1;
        end
      end
      CS_PULSE: if (pulse_end) nxt = CS_WAIT;
      CS_WAIT: begin
        if (wait_end) begin
          if (lock_s) begin
            nxt      = CS_RUN;
            fail_clr = 1'b1;
          end else begin
            nxt       = CS_PULSE;
            retry_inc = 1'b1;
            fail_inc  = 1'b1;
          end
        end
      end
      default: nxt = CS_HOLD;
    endcase
    if (!released) begin
      nxt       = CS_HOLD;
      retry_inc = 1'b0;
      fail_inc  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= CS_HOLD;
      tmr        <= '0;
      fails      <= '0;
      retry_cnt  <= '0;
      chan_err   <= 1'b0;
      chan_rst   <= 1'b1;
      chan_ready <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st || !(st == CS_PULSE || st == CS_WAIT)) tmr <= '0;
      else                                                 tmr <= tmr + 1'b1;

      if (!released)                       retry_cnt <= '0;
      else if (retry_inc && retry_cnt != RMAX) retry_cnt <= retry_cnt + 1'b1;

      if (!released || fail_clr)                       fails <= '0;
      else if (fail_inc && fails != FW'(ERR_LIMIT))    fails <= fails + 1'b1;

      if (fail_inc && fails >= FW'(ERR_LIMIT - 1)) chan_err <= 1'b1;

      chan_rst   <= (nxt == CS_HOLD) || (nxt == CS_PULSE);
      chan_ready <= (nxt == CS_RUN);
    end
  end

  // R11: ready and reset are mutually exclusive
  a_r11_ready_excl: assert property (@(posedge clk) disable iff (rst)
    !(chan_ready && chan_rst));

  // R6: the wait is not cut short by anything except a master lock loss
  a_r6_wait_not_cut: assert property (@(posedge clk) disable iff (rst)
    (st == CS_WAIT && !wait_end && released) |=> (st == CS_WAIT && !chan_ready));

  // R7: missing lock at the end of the wait starts a new pulse
  a_r7_retry_pulse: assert property (@(posedge clk) disable iff (rst)
    (st == CS_WAIT && wait_end && !lock_s && released) |=> (chan_rst && !chan_ready));

  // R8: saturated counter stays saturated while released
  a_r8_retry_sat: assert property (@(posedge clk) disable iff (rst)
    (retry_cnt == RMAX && released) |=> retry_cnt == RMAX);

  // R9: error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    chan_err |=> chan_err);
endmodule

// File: rtl/clk_lock_supervisor.sv
// Top: global settle hold plus one recovery loop per clock-manager channel.
module clk_lock_supervisor #(
  parameter int NUM_CH     = 8,
  parameter int PULSE_CYC  = 8,
  parameter int WAIT_CYC   = 32_500,  // 650 us at 50 MHz
  parameter int SETTLE_CYC = 50_000,  // 1 ms at 50 MHz
  parameter int ERR_LIMIT  = 4,
  parameter int RETRY_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pll_locked,
  input  logic [NUM_CH-1:0]       chan_locked,
  output logic [NUM_CH-1:0]       chan_rst,
  output logic [NUM_CH-1:0]       chan_ready,
  output logic [RETRY_W*NUM_CH-1:0] retry_cnt,
  output logic [NUM_CH-1:0]       chan_err
);
  localparam int SW = NUM_CH + 1;

  logic [SW-1:0]     sync_q;
  logic              pll_s;
  logic [NUM_CH-1:0] lock_s;
  logic              released;

  clksup_sync #(.W(SW), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pll_locked, chan_locked}),
    .q   (sync_q)
  );

  assign pll_s  = sync_q[NUM_CH];
  assign lock_s = sync_q[NUM_CH-1:0];

  clksup_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk      (clk),
    .rst      (rst),
    .pll_s    (pll_s),
    .released (released)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    clksup_chan #(
      .PULSE_CYC (PULSE_CYC),
      .WAIT_CYC  (WAIT_CYC),
      .ERR_LIMIT (ERR_LIMIT),
      .RETRY_W   (RETRY_W)
    ) u_chan (
      .clk        (clk),
      .rst        (rst),
      .released   (released),
      .lock_s     (lock_s[c]),
      .chan_rst   (chan_rst[c]),
      .chan_ready (chan_ready[c]),
      .retry_cnt  (retry_cnt[c*RETRY_W +: RETRY_W]),
      .chan_err   (chan_err[c])
    );
  end

  // R1: without release every channel is (or next cycle is) in reset
  a_r1_hold_all: assert property (@(posedge clk) disable iff (rst)
    !released |=> (&chan_rst && chan_ready == '0));

  // R8: counters cleared while the master lock is absent
  a_r8_clear_on_hold: assert property (@(posedge clk) disable iff (rst)
    !released |=> retry_cnt == '0);
endmodule

// File: tb/tb_clk_lock_supervisor.sv
module tb_clk_lock_supervisor;
  localparam int N  = 8;
  localparam int P  = 3;
  localparam int W  = 20;
  localparam int S  = 30;
  localparam int EL = 3;

  logic clk = 1'b0;
  logic rst;
  logic pll_locked;
  logic [N-1:0]   chan_locked;
  logic [N-1:0]   chan_rst;
  logic [N-1:0]   chan_ready;
  logic [8*N-1:0] retry_cnt;
  logic [N-1:0]   chan_err;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  clk_lock_supervisor #(
    .NUM_CH(N), .PULSE_CYC(P), .WAIT_CYC(W), .SETTLE_CYC(S),
    .ERR_LIMIT(EL), .RETRY_W(8)
  ) dut (
    .clk(clk), .rst(rst), .pll_locked(pll_locked), .chan_locked(chan_locked),
    .chan_rst(chan_rst), .chan_ready(chan_ready), .retry_cnt(retry_cnt),
    .chan_err(chan_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rcnt(input int ch);
    return int'(retry_cnt[ch*8 +: 8]);
  endfunction

  // count negedges until chan_rst[ch] equals v
  task automatic wait_rst(input int ch, input logic v, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (chan_rst[ch] !== v && n < 2000);
  endtask

  task automatic wait_ready(input int ch, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (chan_ready[ch] !== 1'b1 && n < 2000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    bit ok;
    rst = 1'b1; pll_locked = 1'b0; chan_locked = '1;
    repeat (4) @(negedge clk);
    chk(chan_rst == '1 && chan_ready == '0, "R1 reset state", int'(chan_rst), 255);
    chk(chan_err == '0 && retry_cnt == '0, "R1 reset counters", int'(chan_err), 0);
    rst = 1'b0;

    // R1: channel locks ignored while master lock absent
    ok = 1'b1;
    for (int i = 0; i < 12; i++) begin
      chan_locked = 8'(i * 37);
      @(negedge clk);
      if (chan_rst != '1 || chan_ready != '0) ok = 1'b0;
    end
    chk(ok, "R1 hold while pll low", int'(chan_rst), 255);
    chan_locked = '1;
    repeat (3) @(negedge clk);

    // R2 release timing
    pll_locked = 1'b1;
    wait_rst(0, 1'b0, n);
    chk(n == S + 3, "R2 settle release", n, S + 3);
    chk(chan_rst == '0, "R2 all released together", int'(chan_rst), 0);
    // R3 first check window
    wait_ready(0, n);
    chk(n == W, "R3 first lock check", n, W);
    chk(chan_ready == '1, "R3 all ready", int'(chan_ready), 255);

    // R4/R5/R6 per channel loss and recovery, all channels
    for (int ch = 0; ch < N; ch++) begin
      bit others_ok;
      int m;
      chan_locked[ch] = 1'b0;
      wait_rst(ch, 1'b1, n);
      chk(n == 3, "R4 pulse latency", n, 3);
      chan_locked[ch] = 1'b1;
      others_ok = 1'b1;
      m = 1;
      forever begin
        @(negedge clk);
        for (int o = 0; o < N; o++)
          if (o != ch && (chan_ready[o] !== 1'b1 || chan_rst[o] !== 1'b0)) others_ok = 1'b0;
        if (chan_rst[ch] !== 1'b1) break;
        m++;
      end
      chk(m == P, "R4 pulse width", m, P);
      chk(chan_ready[ch] == 1'b0, "R11 not ready in wait", int'(chan_ready[ch]), 0);
      wait_ready(ch, n);
      chk(n == W, "R6 wait length", n, W);
      chk(others_ok, "R5 other channels untouched", 0, 1);
      chk(rcnt(ch) == 1, "R8 retry count one", rcnt(ch), 1);
    end

    // R6: lock toggling in the wait does not end it early
    chan_locked[0] = 1'b0;
    wait_rst(0, 1'b1, n);
    wait_rst(0, 1'b0, n);
    chan_locked[0] = 1'b1;
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    chan_locked[0] = 1'b0;
    repeat (2) begin @(negedge clk); n++; end
    chan_locked[0] = 1'b1;
    while (chan_ready[0] !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    chk(n == W, "R6 toggle inside wait", n, W);
    chk(rcnt(0) == 2, "R8 retry count two", rcnt(0), 2);

    // R7 / R9 / R8 saturation on channel 1
    chan_locked[1] = 1'b0;
    wait_rst(1, 1'b1, n);
    chk(chan_err[1] == 1'b0, "R9 no error after first loss", int'(chan_err[1]), 0);
    for (int r = 2; r <= 300; r++) begin
      int f, g;
      wait_rst(1, 1'b0, f);
      wait_rst(1, 1'b1, g);
      if (r <= 4) begin
        chk(f == P && g == W, "R7 retry period", f + g, P + W);
        chk(chan_ready[0] == 1'b1, "R5 channel 0 unaffected", int'(chan_ready[0]), 1);
      end
      if (r == EL)     chk(chan_err[1] == 1'b0, "R9 below limit", int'(chan_err[1]), 0);
      if (r == EL + 1) chk(chan_err[1] == 1'b1, "R9 at limit", int'(chan_err[1]), 1);
      if (r == 20)     chk(rcnt(1) == 21, "R8 retry increments", rcnt(1), 21);
    end
    chk(rcnt(1) == 255, "R8 retry saturation", rcnt(1), 255);
    chan_locked[1] = 1'b1;
    wait_rst(1, 1'b0, n);
    wait_ready(1, n);
    chk(n == W, "R7 recovers after retries", n, W);
    chk(chan_err[1] == 1'b1 && rcnt(1) == 255, "R9 sticky after recovery", int'(chan_err[1]), 1);
    chk(chan_err == 8'h02, "R9 other errors clear", int'(chan_err), 2);

    // R10 master loss
    pll_locked = 1'b0;
    repeat (4) @(negedge clk);
    chk(chan_rst == '1 && chan_ready == '0, "R10 all held", int'(chan_rst), 255);
    chk(retry_cnt == '0, "R8 cleared on master loss", rcnt(1), 0);
    chk(chan_err[1] == 1'b1, "R9 survives master loss", int'(chan_err[1]), 1);
    repeat (5) @(negedge clk);
    pll_locked = 1'b1;
    wait_rst(3, 1'b0, n);
    chk(n == S + 3, "R10 settle restarts", n, S + 3);
    wait_ready(3, n);
    chk(n == W, "R3 check after relock", n, W);

    // R10 short master glitch still restarts full interval
    pll_locked = 1'b0;
    repeat (3) @(negedge clk);
    pll_locked = 1'b1;
    n = 0;
    while (chan_rst[5] !== 1'b1 && n < 10) begin @(negedge clk); n++; end
    wait_rst(5, 1'b0, n);
    chk(n > S, "R10 glitch restarts settle", n, S + 1);

    // R9 cleared only by reset
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(chan_err == '0, "R9 cleared by reset", int'(chan_err), 0);
    chk(chan_rst == '1 && chan_ready == '0, "R1 reset reapplied", int'(chan_rst), 255);
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule